// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Front End

This block is the digital command front end of a two-channel 16-bit voltage-output converter. A host sends 24-bit words over a three-wire serial link: a clock, an active-low frame-select and a data line. The block brings all three into one system clock domain. It shifts the word in on the falling edges of the serial clock, then decodes an 8-bit control byte that sits above a 16-bit code.

Each channel has two stages. A staging buffer holds a pending code and power mode. An output register holds the code and mode in force. The control byte picks which buffer a word writes, and it carries one load strobe per channel. Each strobe copies that channel's buffer into its output register. Power-down requests use the same buffer-then-load path as ordinary codes. A single word can therefore stage one channel and update either or both channels together. A one-cycle update pulse per channel marks each load.

Top module: `dac_cmd_frontend`

## Requirements
- R1: After reset, both output codes are 0, both power modes are 00 (normal), and no update pulse is high.
- R2: A word is 24 bits, sent most significant bit first and sampled on falling serial-clock edges while frame-select is low. The data line must be stable when it is sampled. The command acts once, on the 24th falling edge. Outputs and the update pulse change at the fourth system clock rising edge after that edge appears at the pins.
- R3: Bit 18 of the word selects the staging buffer: 0 writes channel A and 1 writes channel B. The buffer receives the 16-bit code in bits 15..0 and the mode in bits 17..16.
- R4: Bit 20 loads channel A and bit 21 loads channel B. A loaded channel copies its buffer, including a value written by the same word, into its output code and mode. Both channels may load from one word.
- R5: Mode encoding: 00 is normal, 01 is ground through about 1 kΩ, 10 is ground through about 100 kΩ, and 11 is high impedance. The mode output takes a new value only when its channel loads.
- R6: A word that writes a buffer without setting that channel's load bit leaves that channel's outputs unchanged.
- R7: If frame-select goes high before the 24th falling edge, the partial word is discarded and no buffer, code or mode changes.
- R8: A word with bit 23 or bit 22 set is ignored entirely: no buffer, output or update pulse changes.
- R9: Bit 19 has no effect on any buffer, output or pulse.
- R10: Falling edges after the 24th, within the same low period of frame-select, are ignored.
- R11: Each channel's update pulse is high for exactly one system clock cycle, in the cycle its output register loads, and at no other time.
- R12: A channel in power-down returns to normal only when a word with mode 00 has been written to its buffer and the channel is then loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| frame_n_i | input | 1 | Active-low frame-select, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| code_a_o | output | 16 | Channel A output register code |
| code_b_o | output | 16 | Channel B output register code |
| mode_a_o | output | 2 | Channel A active power mode |
| mode_b_o | output | 2 | Channel B active power mode |
| upd_a_o | output | 1 | One-cycle pulse when channel A loads |
| upd_b_o | output | 1 | One-cycle pulse when channel B loads |

## Verification
Assertions check every cycle that the outputs hold still whenever no update pulse is high, that update pulses never last two cycles, and that the bit counter clears whenever frame-select is high and never wraps within a frame. They also check that a completed word with a reserved bit set never produces a load. Other behaviours depend on the content of the words and on their order in a sequence, and only the bench scenarios can show them. These include the order of buffer write and load within one word, channel B loading a buffer staged by an earlier word, the exit from power-down, discarding of aborted words, and the exact cycle of each update. A behavioural model runs alongside the design and is compared with it on every clock.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int FRAME_W = 24;
  localparam int CODE_W  = 16;
  localparam int N_CHAN  = 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PM_NORMAL   = 2'b00,
    PM_GND_LOW  = 2'b01,
    PM_GND_HIGH = 2'b10,
    PM_FLOAT    = 2'b11
  } pwr_mode_e;

  // Bit layout of a completed word, most significant field first.
  typedef struct packed {
    logic [1:0]        rsvd;
    logic              load_b;
    logic              load_a;
    logic              ignore;
    logic              sel_b;
    pwr_mode_e         mode;
    logic [CODE_W-1:0] code;
  } cmd_word_t;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift
  import dac_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               frame_n_s,
  input  logic               sdat_s,
  output logic [FRAME_W-1:0] word_o,
  output logic               done_o
);
  logic               sclk_prev_q;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               done_q, done_d;
  logic               fall, active;

  assign active = !frame_n_s;
  assign fall   = sclk_prev_q && !sclk_s;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (!active) begin
      shreg_d = '0;
      cnt_d   = '0;
    end else if (fall && (cnt_q < CNT_W'(FRAME_W))) begin
      shreg_d = {shreg_q[FRAME_W-2:0], sdat_s};
      cnt_d   = cnt_q + 1'b1;
      done_d  = (cnt_q == CNT_W'(FRAME_W - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      shreg_q     <= '0;
      cnt_q       <= '0;
      done_q      <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      shreg_q     <= shreg_d;
      cnt_q       <= cnt_d;
      done_q      <= done_d;
    end
  end

  assign word_o = shreg_q;
  assign done_o = done_q;

  // R7: a high frame-select empties the counter and blocks completion
  a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0) && !done_q);
  // R10: a full counter never wraps inside one frame
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(FRAME_W)) |=> (cnt_q == CNT_W'(FRAME_W)) || (cnt_q == '0));
  // R2: completion only with all bits received
  a_r2_done_full: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == CNT_W'(FRAME_W)));
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import dac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  pwr_mode_e         wr_mode,
  input  logic              ld_en,
  output logic [CODE_W-1:0] code_o,
  output pwr_mode_e         mode_o,
  output logic              upd_o
);
  logic [CODE_W-1:0] buf_code_q, buf_code_d, out_code_q, out_code_d;
  pwr_mode_e         buf_mode_q, buf_mode_d, out_mode_q, out_mode_d;
  logic              upd_q;

  always_comb begin
    buf_code_d = wr_en ? wr_code : buf_code_q;
    buf_mode_d = wr_en ? wr_mode : buf_mode_q;
    out_code_d = ld_en ? buf_code_d : out_code_q;
    out_mode_d = ld_en ? buf_mode_d : out_mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_code_q <= '0;
      buf_mode_q <= PM_NORMAL;
      out_code_q <= '0;
      out_mode_q <= PM_NORMAL;
      upd_q      <= 1'b0;
    end else begin
      if (wr_en) begin
        buf_code_q <= buf_code_d;
        buf_mode_q <= buf_mode_d;
      end
      if (ld_en) begin
        out_code_q <= out_code_d;
        out_mode_q <= out_mode_d;
      end
      upd_q <= ld_en;
    end
  end

  assign code_o = out_code_q;
  assign mode_o = out_mode_q;
  assign upd_o  = upd_q;

  // R6: outputs only move in a cycle flagged by the update pulse
  a_r6_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> $stable(out_code_q) && $stable(out_mode_q));
  // R11: load requests never arrive back to back, so pulses last one cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
endmodule

// File: rtl/dac_cmd_frontend.sv
module dac_cmd_frontend
  import dac_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk_i,
  input  logic        frame_n_i,
  input  logic        ser_dat_i,
  output logic [15:0] code_a_o,
  output logic [15:0] code_b_o,
  output logic [1:0]  mode_a_o,
  output logic [1:0]  mode_b_o,
  output logic        upd_a_o,
  output logic        upd_b_o
);
  logic               rst_i_n;
  logic [2:0]         pins_s;
  logic [FRAME_W-1:0] word;
  logic               done;
  cmd_word_t          cmd;
  logic               valid;
  logic [N_CHAN-1:0]  wr_en, ld_en, upd;
  logic [CODE_W-1:0]  code_q [N_CHAN];
  pwr_mode_e          mode_q [N_CHAN];
  logic               unused_ignore_bit;

  dac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  // order: {serial clock, frame-select, data}; frame-select idles high
  dac_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_i_n),
    .async_i({ser_clk_i, frame_n_i, ser_dat_i}), .sync_o(pins_s));

  dac_frame_shift u_shift (
    .clk(clk), .rst_n(rst_i_n),
    .sclk_s(pins_s[2]), .frame_n_s(pins_s[1]), .sdat_s(pins_s[0]),
    .word_o(word), .done_o(done));

  assign cmd               = cmd_word_t'(word);
  assign valid             = done && (cmd.rsvd == 2'b00);
  assign unused_ignore_bit = cmd.ignore;

  always_comb begin
    wr_en[0] = valid && !cmd.sel_b;
    wr_en[1] = valid &&  cmd.sel_b;
    ld_en[0] = valid &&  cmd.load_a;
    ld_en[1] = valid &&  cmd.load_b;
  end

  generate
    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      dac_chan_regs u_chan (
        .clk(clk), .rst_n(rst_i_n),
        .wr_en(wr_en[c]), .wr_code(cmd.code), .wr_mode(cmd.mode),
        .ld_en(ld_en[c]),
        .code_o(code_q[c]), .mode_o(mode_q[c]), .upd_o(upd[c]));
    end
  endgenerate

  assign code_a_o = code_q[0];
  assign code_b_o = code_q[1];
  assign mode_a_o = mode_q[0];
  assign mode_b_o = mode_q[1];
  assign upd_a_o  = upd[0];
  assign upd_b_o  = upd[1];

  // R8: a completed word with a reserved bit set loads nothing
  a_r8_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && (cmd.rsvd != 2'b00)) |=> !upd_a_o && !upd_b_o);
  // R4: a clean word with a load bit pulses that channel next cycle
  a_r4_load_a_follows: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && (cmd.rsvd == 2'b00) && cmd.load_a) |=> upd_a_o);
  a_r4_load_b_follows: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && (cmd.rsvd == 2'b00) && cmd.load_b) |=> upd_b_o);
endmodule

// File: tb/dac_cmd_frontend_bench.sv
module dac_cmd_frontend_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, frame_n = 1'b1, ser_dat = 1'b0;
  logic [15:0] code_a, code_b;
  logic [1:0]  mode_a, mode_b;
  logic        upd_a, upd_b;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  dac_cmd_frontend u_dac_cmd_frontend (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(ser_clk), .frame_n_i(frame_n), .ser_dat_i(ser_dat),
    .code_a_o(code_a), .code_b_o(code_b), .mode_a_o(mode_a), .mode_b_o(mode_b),
    .upd_a_o(upd_a), .upd_b_o(upd_b));

  // behavioural reference state
  int m_buf_code [2];
  int m_buf_mode [2];
  int m_code [2];
  int m_mode [2];
  int m_upd  [2];
  int pend_cnt = 0;
  logic [23:0] pend_word;
  bit compare_on = 0;

  task automatic apply_word(input logic [23:0] w);
    int sel;
    if (w[23:22] != 2'b00) return;
    sel = w[18] ? 1 : 0;
    m_buf_code[sel] = int'(w[15:0]);
    m_buf_mode[sel] = int'(w[17:16]);
    if (w[20]) begin m_code[0] = m_buf_code[0]; m_mode[0] = m_buf_mode[0]; m_upd[0] = 1; end
    if (w[21]) begin m_code[1] = m_buf_code[1]; m_mode[1] = m_buf_mode[1]; m_upd[1] = 1; end
  endtask

  always @(posedge clk) begin
    m_upd[0] = 0;
    m_upd[1] = 0;
    if (pend_cnt > 0) begin
      pend_cnt = pend_cnt - 1;
      if (pend_cnt == 0) apply_word(pend_word);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (compare_on) begin
      chk(cur_req, "cycle code_a", int'(code_a), m_code[0]);
      chk(cur_req, "cycle code_b", int'(code_b), m_code[1]);
      chk(cur_req, "cycle mode_a", int'(mode_a), m_mode[0]);
      chk(cur_req, "cycle mode_b", int'(mode_b), m_mode[1]);
      chk("R11",   "cycle upd_a",  int'(upd_a),  m_upd[0]);
      chk("R11",   "cycle upd_b",  int'(upd_b),  m_upd[1]);
    end
  end

  function automatic logic [23:0] mk(input logic [1:0] rsvd, input logic ldb,
      input logic lda, input logic ign, input logic selb, input logic [1:0] pd,
      input logic [15:0] data);
    return {rsvd, ldb, lda, ign, selb, pd, data};
  endfunction

  // nbits < 24 aborts the word; extra adds falling edges after the 24th
  task automatic send(input logic [23:0] w, input int nbits, input int extra);
    @(negedge clk);
    frame_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = w[23-i];
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      if (i == 23) begin
        pend_word = w;
        pend_cnt  = 4;
      end
      repeat (4) @(negedge clk);
    end
    for (int j = 0; j < extra; j++) begin
      ser_dat = j[0];
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    frame_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  int pulses_a = 0;
  always @(negedge clk) if (upd_a) pulses_a++;

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_buf_code[c] = 0; m_buf_mode[c] = 0; m_code[c] = 0; m_mode[c] = 0; m_upd[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "code_a", int'(code_a), 0);
    chk("R1", "code_b", int'(code_b), 0);
    chk("R1", "mode_a", int'(mode_a), 0);
    chk("R1", "mode_b", int'(mode_b), 0);
    chk("R1", "upd", int'({upd_a, upd_b}), 0);
    compare_on = 1;

    // R6: stage A without load
    cur_req = "R6";
    send(mk(2'b00, 0, 0, 0, 0, 2'b00, 16'h1234), 24, 0);
    chk("R6", "code_a unchanged", int'(code_a), 0);

    // R2 / R3: stage and load A in one word
    cur_req = "R2";
    send(mk(2'b00, 0, 1, 0, 0, 2'b00, 16'hA5C3), 24, 0);
    chk("R2", "code_a loaded", int'(code_a), 16'hA5C3);
    chk("R3", "code_b untouched", int'(code_b), 0);

    // R4: stage B, load both
    cur_req = "R4";
    send(mk(2'b00, 1, 1, 0, 1, 2'b00, 16'h0F0F), 24, 0);
    chk("R4", "code_a from buffer", int'(code_a), 16'hA5C3);
    chk("R4", "code_b new", int'(code_b), 16'h0F0F);

    // R5: power-down B to 100k mode
    cur_req = "R5";
    send(mk(2'b00, 1, 0, 0, 1, 2'b10, 16'hFFFF), 24, 0);
    chk("R5", "mode_b 100k", int'(mode_b), 2);
    chk("R5", "mode_a normal", int'(mode_a), 0);

    // R7: aborted word after 12 bits
    cur_req = "R7";
    send(mk(2'b00, 1, 1, 0, 0, 2'b11, 16'h7777), 12, 0);
    send(mk(2'b00, 0, 0, 0, 1, 2'b00, 16'h2222), 23, 0);
    chk("R7", "code_a kept", int'(code_a), 16'hA5C3);
    chk("R7", "mode_a kept", int'(mode_a), 0);

    // R8: reserved bits
    cur_req = "R8";
    send(mk(2'b10, 1, 1, 0, 0, 2'b01, 16'h5555), 24, 0);
    send(mk(2'b01, 1, 1, 0, 1, 2'b01, 16'h6666), 24, 0);
    chk("R8", "code_a kept", int'(code_a), 16'hA5C3);
    chk("R8", "code_b kept", int'(code_b), 16'hFFFF);
    chk("R8", "mode_b kept", int'(mode_b), 2);

    // R9: ignored bit set
    cur_req = "R9";
    send(mk(2'b00, 0, 1, 1, 0, 2'b00, 16'h3C3C), 24, 0);
    chk("R9", "code_a loaded", int'(code_a), 16'h3C3C);

    // R10: extra edges after the 24th
    cur_req = "R10";
    send(mk(2'b00, 0, 1, 0, 0, 2'b00, 16'h1111), 24, 8);
    chk("R10", "code_a loaded once", int'(code_a), 16'h1111);

    // R5: remaining power-down codes on A
    cur_req = "R5";
    send(mk(2'b00, 0, 1, 0, 0, 2'b01, 16'h0001), 24, 0);
    chk("R5", "mode_a 1k", int'(mode_a), 1);
    send(mk(2'b00, 0, 1, 0, 0, 2'b11, 16'h0002), 24, 0);
    chk("R5", "mode_a float", int'(mode_a), 3);

    // R12: leave power-down on B only after staged 00 plus load
    cur_req = "R12";
    send(mk(2'b00, 0, 0, 0, 1, 2'b00, 16'h4321), 24, 0);
    chk("R12", "mode_b still down", int'(mode_b), 2);
    send(mk(2'b00, 1, 0, 0, 0, 2'b01, 16'h9999), 24, 0);
    chk("R12", "mode_b normal", int'(mode_b), 0);
    chk("R12", "code_b staged", int'(code_b), 16'h4321);
    chk("R12", "mode_a unchanged", int'(mode_a), 3);

    // R11: one pulse per A load (six A loads so far)
    chk("R11", "upd_a pulse count", pulses_a, 6);

    compare_on = 0;
    summary();
    $finish;
  end
endmodule